// File: doc/BRIEF.md
# Slot-Based Interrupt Router

This block takes an interrupt notification raised by a device on a PCI bus, identified by its device/function code and the interrupt pin it uses (INTA to INTD), and turns it into an internal interrupt line number through a fixed board table. That table gives each slot its own rule. One slot spreads its four pins over four consecutive lines. Two slots are tied to a single line each. A run of add-in slots rotates the pins by slot position. Any unknown slot passes its pin number through untouched.

The mapped line also selects a bit in two configuration words supplied by the register file. One bit chooses pulse or level behaviour. The other gives the level to drive. Together they decide what the single registered interrupt output towards the CPU does.

Notifications arrive on a valid/ready stream. The mapped line leaves on a second valid/ready stream held in a single output register. The input is ready whenever that register is empty or is being emptied in the same cycle, so a stalled consumer stalls the producer with no loss and no duplication. The CPU interrupt output is driven in the cycle after a notification is accepted, whatever the state of the output stream.

Top module: `irq_slot_router`

## Requirements
- R1: The slot number is the device/function code shifted right by three; the low three bits (function number) never change the mapped line.
- R2: Slot 5 maps pin n (0 = INTA .. 3 = INTD) to line 32 + n.
- R3: Slot 6 maps every pin to line 36, and slot 7 maps every pin to line 37.
- R4: Slots 8 to 12 map pin n to line (slot - 8 + n) + 38.
- R5: Any other slot yields a line equal to the pin number.
- R6: When the line is 32 or above and bit (line - 32) of the edge word is 1, `cpu_irq` is 1 in the cycle after acceptance and 0 in the cycle after that unless another notification is accepted; the held level becomes 0.
- R7: When the line is 32 or above and its edge bit is 0, `cpu_irq` takes bit (line - 32) of the polarity word from the cycle after acceptance and keeps it until the next such notification.
- R8: A notification whose line is below 32 leaves the held level on `cpu_irq` unchanged.
- R9: `map_valid` rises in the cycle after acceptance with `map_line`; while `map_valid` is 1 and `map_ready` is 0 both hold and `evt_ready` is 0; `evt_ready` equals `!map_valid || map_ready`.
- R10: After reset `map_valid` and `cpu_irq` are 0 and `evt_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Interrupt notification present |
| evt_ready | output | 1 | Notification accepted this cycle when valid |
| evt_devfn | input | 8 | Device/function code of the requester |
| evt_pin | input | 2 | Interrupt pin, 0 = INTA to 3 = INTD |
| edge_cfg | input | 32 | Per-line pulse select, bit i for line 32 + i |
| pol_cfg | input | 32 | Per-line level value, bit i for line 32 + i |
| map_valid | output | 1 | Mapped line available |
| map_ready | input | 1 | Consumer takes the mapped line |
| map_line | output | 6 | Mapped interrupt line number |
| cpu_irq | output | 1 | Registered interrupt output to the CPU |

## Verification
The output register can be drained by the consumer and refilled by a new notification in the same cycle. The bench holds a first result with `map_ready` low, then raises `map_ready` and presents a second notification together. The scoreboard must see the first line once and the second line in the very next cycle. The CPU output must show the second notification's effect at the same time, with no bubble and no lost or repeated item.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Board slot table
  localparam int SOUTH_SLOT = 5;
  localparam int VIDEO_SLOT = 6;
  localparam int NET_SLOT   = 7;
  localparam int SWZ_FIRST  = 8;
  localparam int SWZ_LAST   = 12;
  // Offsets above the line base
  localparam int VIDEO_OFS  = 4;
  localparam int NET_OFS    = 5;
  localparam int SWZ_OFS    = 6;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_PULSE = 2'd1,
    ACT_LEVEL = 2'd2
  } drive_act_e;
endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import irq_route_pkg::*;
#(
  parameter int DEVFN_W   = 8,
  parameter int PIN_W     = 2,
  parameter int LINE_W    = 6,
  parameter int LINE_BASE = 32
) (
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [PIN_W-1:0]   pin,
  output logic [LINE_W-1:0]  line
);
  localparam int SLOT_W = DEVFN_W - 3;

  logic [SLOT_W-1:0] slot;
  logic [2:0]        unused_func;

  assign slot        = devfn[DEVFN_W-1:3];
  assign unused_func = devfn[2:0];

  always_comb begin
    line = LINE_W'(pin);
    if (slot == SLOT_W'(SOUTH_SLOT)) begin
      line = LINE_W'(LINE_BASE) + LINE_W'(pin);
    end else if (slot == SLOT_W'(VIDEO_SLOT)) begin
      line = LINE_W'(LINE_BASE + VIDEO_OFS);
    end else if (slot == SLOT_W'(NET_SLOT)) begin
      line = LINE_W'(LINE_BASE + NET_OFS);
    end else if (slot >= SLOT_W'(SWZ_FIRST) && slot <= SLOT_W'(SWZ_LAST)) begin
      line = LINE_W'(LINE_BASE + SWZ_OFS - SWZ_FIRST) + LINE_W'(slot) + LINE_W'(pin);
    end
  end
endmodule

// File: rtl/irq_cpu_drive.sv
module irq_cpu_drive
  import irq_route_pkg::*;
#(
  parameter int LINE_W    = 6,
  parameter int NCFG      = 32,
  parameter int LINE_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [LINE_W-1:0] line,
  input  logic [NCFG-1:0]   edge_cfg,
  input  logic [NCFG-1:0]   pol_cfg,
  output logic              cpu_irq
);
  localparam int IDX_W = (NCFG > 1) ? $clog2(NCFG) : 1;

  logic [31:0]      lv;
  logic             in_range;
  logic [IDX_W-1:0] idx;
  drive_act_e       act;
  logic             irq_q;
  logic             lvl_q;

  assign lv       = 32'(line);
  assign in_range = (lv >= 32'(LINE_BASE)) && (lv < 32'(LINE_BASE + NCFG));
  assign idx      = IDX_W'(lv - 32'(LINE_BASE));

  always_comb begin
    if (!fire || !in_range)  act = ACT_HOLD;
    else if (edge_cfg[idx])  act = ACT_PULSE;
    else                     act = ACT_LEVEL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      case (act)
        ACT_PULSE: begin
          irq_q <= 1'b1;
          lvl_q <= 1'b0;
        end
        ACT_LEVEL: begin
          irq_q <= pol_cfg[idx];
          lvl_q <= pol_cfg[idx];
        end
        default: irq_q <= lvl_q;
      endcase
    end
  end

  assign cpu_irq = irq_q;

  AST_PULSE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_PULSE) |=> cpu_irq); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_PULSE) ##1 (act == ACT_HOLD) |=> !cpu_irq); // R6

  AST_LEVEL_POL: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LEVEL) |=> (cpu_irq == $past(pol_cfg[idx]))); // R7

  AST_HOLD_AFTER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LEVEL) ##1 (act == ACT_HOLD) |=> $stable(cpu_irq)); // R8
endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router #(
  parameter int DEVFN_W   = 8,
  parameter int PIN_W     = 2,
  parameter int LINE_W    = 6,
  parameter int NCFG      = 32,
  parameter int LINE_BASE = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  output logic               evt_ready,
  input  logic [DEVFN_W-1:0] evt_devfn,
  input  logic [PIN_W-1:0]   evt_pin,
  input  logic [NCFG-1:0]    edge_cfg,
  input  logic [NCFG-1:0]    pol_cfg,
  output logic               map_valid,
  input  logic               map_ready,
  output logic [LINE_W-1:0]  map_line,
  output logic               cpu_irq
);
  logic              accept;
  logic [LINE_W-1:0] mapped;
  logic              out_vld_q;
  logic [LINE_W-1:0] out_line_q;

  assign evt_ready = !out_vld_q || map_ready;
  assign accept    = evt_valid && evt_ready;

  irq_slot_map #(
    .DEVFN_W  (DEVFN_W),
    .PIN_W    (PIN_W),
    .LINE_W   (LINE_W),
    .LINE_BASE(LINE_BASE)
  ) i_map (
    .devfn(evt_devfn),
    .pin  (evt_pin),
    .line (mapped)
  );

  irq_cpu_drive #(
    .LINE_W   (LINE_W),
    .NCFG     (NCFG),
    .LINE_BASE(LINE_BASE)
  ) i_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (accept),
    .line    (mapped),
    .edge_cfg(edge_cfg),
    .pol_cfg (pol_cfg),
    .cpu_irq (cpu_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld_q  <= 1'b0;
      out_line_q <= '0;
    end else if (accept) begin
      out_vld_q  <= 1'b1;
      out_line_q <= mapped;
    end else if (map_ready) begin
      out_vld_q  <= 1'b0;
    end
  end

  assign map_valid = out_vld_q;
  assign map_line  = out_line_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && !map_ready) |=> (map_valid && $stable(map_line))); // R9

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready) |=> map_valid); // R9
endmodule

// File: tb/test_irq_slot_router.sv
`timescale 1ns/1ps
module test_irq_slot_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [7:0]  evt_devfn = '0;
  logic [1:0]  evt_pin = '0;
  logic [31:0] edge_cfg = 32'h0000_0090;
  logic [31:0] pol_cfg  = 32'h0000_2023;
  logic        map_valid;
  logic        map_ready = 1'b1;
  logic [5:0]  map_line;
  logic        cpu_irq;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    exp_lvl = 1'b0;

  always #10 clk = ~clk;

  irq_slot_router i_irq_slot_router (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_devfn(evt_devfn), .evt_pin(evt_pin), .edge_cfg(edge_cfg),
    .pol_cfg(pol_cfg), .map_valid(map_valid), .map_ready(map_ready),
    .map_line(map_line), .cpu_irq(cpu_irq)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_line(int slot, int pin);
    if (slot == 5) return 32 + (pin % 4);
    if (slot == 6) return 36;
    if (slot == 7) return 37;
    if (slot >= 8 && slot <= 12) return (slot - 8 + pin) + 38;
    return pin;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && map_valid && map_ready) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9: got line %0d expected none", map_line);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (int'(map_line) != e) begin
          n_bad++;
          $display("FAIL %s: got line %0d expected %0d", t, map_line, e);
        end
      end
    end
  end

  task automatic send(int slot, int func, int pin, bit release_rdy, string tag);
    int    line;
    bit    in_rng, e, p, first;
    string ct;
    line   = ref_line(slot, pin);
    in_rng = (line >= 32) && (line < 64);
    e      = in_rng && edge_cfg[line-32];
    p      = in_rng && pol_cfg[line-32];
    ct     = !in_rng ? "R8" : (e ? "R6" : "R7");
    exp_q.push_back(line);
    tag_q.push_back(tag);
    @(posedge clk); #2;
    evt_valid = 1'b1;
    evt_devfn = 8'(slot * 8 + func);
    evt_pin   = 2'(pin);
    if (release_rdy) map_ready = 1'b1;
    @(negedge clk);
    while (!evt_ready) @(negedge clk);
    @(posedge clk); #2;
    evt_valid = 1'b0;
    @(negedge clk);
    first = !in_rng ? exp_lvl : (e ? 1'b1 : p);
    chk({ct, " first cycle"}, int'(cpu_irq), int'(first));
    if (in_rng) exp_lvl = e ? 1'b0 : p;
    @(negedge clk);
    chk({ct, " second cycle"}, int'(cpu_irq), int'(exp_lvl));
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 map_valid", int'(map_valid), 0);
    chk("R10 cpu_irq", int'(cpu_irq), 0);
    chk("R10 evt_ready", int'(evt_ready), 1);

    // R2 south slot, all pins, function bits varied (R1)
    send(5, 1, 0, 0, "R2");
    send(5, 3, 1, 0, "R2/R1");
    send(5, 2, 2, 0, "R2");
    send(5, 0, 3, 0, "R2");
    // R3 fixed slots, R6 pulse on line 36
    send(6, 0, 2, 0, "R3");
    send(7, 4, 3, 0, "R3");
    // R5 pass-through, R8 level held
    send(0, 0, 2, 0, "R5");
    send(13, 6, 1, 0, "R5");
    // R4 swizzled slots
    send(8, 0, 0, 0, "R4");
    send(9, 0, 1, 0, "R4");
    send(12, 0, 3, 0, "R4");
    send(11, 0, 1, 0, "R4");
    send(10, 7, 1, 0, "R4/R1");
    // R6 pulse while level is high, then R8 below base keeps low
    send(12, 5, 3, 0, "R4");
    send(9, 0, 0, 0, "R6");
    send(1, 0, 3, 0, "R5");

    // R9 back-pressure: hold result, then drain and refill in one cycle
    @(posedge clk); #2 map_ready = 1'b0;
    send(12, 0, 3, 0, "R9");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 stalled valid", int'(map_valid), 1);
      chk("R9 stalled line", int'(map_line), 45);
      chk("R9 stalled ready", int'(evt_ready), 0);
    end
    send(6, 0, 1, 1, "R9/R3");
    @(negedge clk);
    chk("R9 ready after drain", int'(evt_ready), 1);

    repeat (4) @(negedge clk);
    chk("R9 all results seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule